// File: doc/BRIEF.md
# Complementary PWM Shoot-Through Detector

This block guards three pairs of complementary PWM output pins against both pins of a pair driving their active level at once, the condition that would short a half-bridge. Each pin is compared with its own polarity bit. When both pins of a pair are active in the same clock cycle and that pair's detection enable is high, a sticky detection flag is set. While the flag is set, the block can raise an interrupt request and can assert a disable signal that places the target outputs in high impedance. Each of these two actions has its own enable bit.

Software reaches a single 16-bit control/status word through a simple strobed read/write port. The high-impedance enable can be written only once after reset. The flag is cleared by a two-step sequence: a read that returns the flag as 1, then a write of 0. That write takes effect only while every monitored pin is at its inactive level. The PWM timer and the pin multiplexing sit outside this block. All pin inputs are assumed to be already synchronous to `clk`.

Top module: `pwm_overlap_guard`

## Requirements
- R1: After a synchronous active-low reset, `acc_rdata`, `irq_req` and `out_hiz` are all 0.
- R2: Pair k consists of pin bits 2k and 2k+1 of `pin_lvl`. A pin is active when its level equals its bit in `pin_pol`. If both pins of a pair are active at a clock edge while `pair_en[k]` is 1, bit 15 of `acc_rdata` (the flag) reads 1 from the next cycle on. It stays 1 after the pins return to inactive.
- R3: A pair whose `pair_en` bit is 0 never sets the flag, and a single active pin of a pair never sets it.
- R4: Bits 7..0 and 14..10 of `acc_rdata` always read 0, and writes to them have no effect.
- R5: `irq_req` equals flag AND bit 8. Every write (`acc_en`=1, `acc_wr`=1) loads bit 8 from `acc_wdata[8]`.
- R6: `out_hiz` equals flag AND bit 9.
- R7: The first write after reset loads bit 9 from `acc_wdata[9]`. Every later write leaves bit 9 unchanged.
- R8: Writing 1 to bit 15 never changes the flag. A write of 0 clears it only if, since the previous write, a read (`acc_en`=1, `acc_wr`=0) has seen the flag as 1.
- R9: A clearing write has no effect unless all six pins are at their inactive level at that clock edge.
- R10: Any write cancels a preceding qualifying read, so a second clear attempt needs a new read of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read when `acc_en` is 1 |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Current register contents |
| pin_lvl | input | 6 | Levels of the six monitored pins |
| pin_pol | input | 6 | Active level of each pin |
| pair_en | input | 3 | Per-pair detection enable |
| irq_req | output | 1 | Interrupt request |
| out_hiz | output | 1 | Output high-impedance request |

## Verification
A flag that is wrongly set, lost or cleared appears on bit 15 of `acc_rdata` one cycle after the offending edge. It appears at the same moment on `irq_req` or `out_hiz` whenever the matching enable is set. A wrong arming state shows up only at the next write of 0: the flag stays 1 when it should clear, or clears when it should stay. The bench therefore follows every clear attempt with an immediate read-out of the word. A broken write-once lock stays hidden until a second write changes bit 9. The bench makes such a write after each reset.

// File: rtl/pog_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and field positions of the shoot-through detector.
// Assumes one 16-bit control word; field positions are decoded by software.
package pog_pkg;
    localparam int NUM_PAIRS = 3;
    localparam int REG_W     = 16;
    localparam int BIT_IE    = 8;
    localparam int BIT_HZE   = 9;
    localparam int BIT_FLAG  = 15;
endpackage

// File: rtl/pog_pair_detect.sv
`timescale 1ns/1ps
// Module: pog_pair_detect
// Compares each pin with its polarity and flags every enabled pair whose two
// pins are active together. Purely combinational; pins assumed synchronous.
module pog_pair_detect #(
    parameter int NUM_PAIRS = pog_pkg::NUM_PAIRS,
    localparam int PINS     = 2 * NUM_PAIRS
) (
    input  logic [PINS-1:0]      pin_lvl,
    input  logic [PINS-1:0]      pin_pol,
    input  logic [NUM_PAIRS-1:0] pair_en,
    output logic [NUM_PAIRS-1:0] pair_hit,
    output logic                 any_active
);
    logic [PINS-1:0] pin_act;

    // Per-pin activity: level matches its polarity bit.
    always_comb pin_act = ~(pin_lvl ^ pin_pol);

    // Any pin at its active level blocks a flag clear.
    always_comb any_active = |pin_act;

    genvar k;
    generate
        for (k = 0; k < NUM_PAIRS; k++) begin : g_pair
            // Overlap of one pair, gated by that pair's enable.
            always_comb pair_hit[k] = pair_en[k] & pin_act[2*k] & pin_act[2*k+1];
        end
    endgenerate
endmodule

// File: rtl/pog_access_arm.sv
`timescale 1ns/1ps
// Module: pog_access_arm
// Remembers that a read has returned the flag as 1 since the last write.
// Any write drops the memory; a read with the flag at 0 leaves it alone.
module pog_access_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic flag,
    output logic armed
);
    // Arm on a read that saw 1, disarm on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (wr_stb) armed <= 1'b0;
        else if (rd_stb && flag) armed <= 1'b1;
    end

    p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !armed);
endmodule

// File: rtl/pog_csr.sv
`timescale 1ns/1ps
// Module: pog_csr
// Holds the interrupt enable, write-once high-impedance enable and the sticky
// detection flag; builds the read word with reserved bits at 0.
// Assumes set has priority over a clear in the same cycle.
module pog_csr #(
    parameter int REG_W = pog_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wdata,
    input  logic             armed,
    input  logic             det_set,
    input  logic             any_active,
    output logic             flag,
    output logic             ie,
    output logic             hze,
    output logic [REG_W-1:0] rdata
);
    import pog_pkg::*;
    logic hze_locked;
    logic clr_ok;

    // Clear qualifies: armed write of 0 while every pin is inactive.
    always_comb clr_ok = wr_stb && armed && !wdata[BIT_FLAG] && !any_active;

    // Sticky flag: clear first, then set so a new overlap wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else begin
            if (clr_ok)  flag <= 1'b0;
            if (det_set) flag <= 1'b1;
        end
    end

    // Interrupt enable follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie <= 1'b0;
        else if (wr_stb) ie <= wdata[BIT_IE];
    end

    // High-impedance enable loads on the first write only, then locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hze        <= 1'b0;
            hze_locked <= 1'b0;
        end else if (wr_stb && !hze_locked) begin
            hze        <= wdata[BIT_HZE];
            hze_locked <= 1'b1;
        end
    end

    // Read word: only the three defined fields are ever non-zero.
    always_comb begin
        rdata           = '0;
        rdata[BIT_IE]   = ie;
        rdata[BIT_HZE]  = hze;
        rdata[BIT_FLAG] = flag;
    end

    p_flag_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_set |=> flag);
    p_no_clear_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);
    p_clear_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && any_active) |=> flag);
    p_hze_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hze_locked |=> $stable(hze));
endmodule

// File: rtl/pwm_overlap_guard.sv
`timescale 1ns/1ps
// Module: pwm_overlap_guard
// Top of the complementary PWM shoot-through detector: pair detection,
// read arming and the control/status word, plus the two request outputs.
// Assumes pin inputs are synchronous to clk.
module pwm_overlap_guard #(
    parameter int NUM_PAIRS = pog_pkg::NUM_PAIRS,
    parameter int REG_W     = pog_pkg::REG_W,
    localparam int PINS     = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 acc_wr,
    input  logic [REG_W-1:0]     acc_wdata,
    output logic [REG_W-1:0]     acc_rdata,
    input  logic [PINS-1:0]      pin_lvl,
    input  logic [PINS-1:0]      pin_pol,
    input  logic [NUM_PAIRS-1:0] pair_en,
    output logic                 irq_req,
    output logic                 out_hiz
);
    import pog_pkg::*;
    logic [NUM_PAIRS-1:0] pair_hit;
    logic any_active, det_set, rd_stb, wr_stb, armed, flag, ie, hze;

    // Decode the access strobe into read and write.
    always_comb begin
        rd_stb = acc_en && !acc_wr;
        wr_stb = acc_en && acc_wr;
    end

    // Any enabled pair overlapping sets the flag.
    always_comb det_set = |pair_hit;

    pog_pair_detect #(.NUM_PAIRS(NUM_PAIRS)) u_detect (
        .pin_lvl(pin_lvl), .pin_pol(pin_pol), .pair_en(pair_en),
        .pair_hit(pair_hit), .any_active(any_active));

    pog_access_arm u_arm (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .flag(flag), .armed(armed));

    pog_csr #(.REG_W(REG_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(acc_wdata),
        .armed(armed), .det_set(det_set), .any_active(any_active),
        .flag(flag), .ie(ie), .hze(hze), .rdata(acc_rdata));

    // Request outputs gated by their enables.
    always_comb begin
        irq_req = flag & ie;
        out_hiz = flag & hze;
    end

    p_irq_matches_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (acc_rdata[BIT_FLAG] & acc_rdata[BIT_IE]));
    p_hiz_matches_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_hiz == (acc_rdata[BIT_FLAG] & acc_rdata[BIT_HZE]));
endmodule

// File: tb/pwm_overlap_guard_tb.sv
`timescale 1ns/1ps
module pwm_overlap_guard_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_wr = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic [5:0] pin_lvl, pin_pol;
    logic [2:0] pair_en = '0;
    logic irq_req, out_hiz;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    logic [15:0] q_rd[$];
    logic        q_irq[$];
    logic        q_hiz[$];
    string       q_tag[$];

    // Model state derived from the requirements.
    logic m_flag = 0, m_ie = 0, m_hze = 0, m_lock = 0, m_arm = 0;

    always #5 clk = ~clk;

    pwm_overlap_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pin_lvl(pin_lvl),
        .pin_pol(pin_pol), .pair_en(pair_en), .irq_req(irq_req), .out_hiz(out_hiz));

    // Monitor: compare every queued expectation away from the active edge.
    always @(negedge clk) begin
        while (q_rd.size() > 0) begin
            logic [15:0] e_rd;
            logic e_irq, e_hiz;
            string t;
            e_rd = q_rd.pop_front(); e_irq = q_irq.pop_front();
            e_hiz = q_hiz.pop_front(); t = q_tag.pop_front();
            vectors++;
            if (acc_rdata !== e_rd || irq_req !== e_irq || out_hiz !== e_hiz) begin
                miscompares++;
                $display("FAIL %s: rdata=%h irq=%b hiz=%b expected rdata=%h irq=%b hiz=%b",
                         t, acc_rdata, irq_req, out_hiz, e_rd, e_irq, e_hiz);
            end
        end
    end

    function automatic logic [5:0] pins(input logic [5:0] act_mask);
        return (pin_pol & act_mask) | (~pin_pol & ~act_mask);
    endfunction

    // One clock: update the model from the inputs at the edge, then queue.
    task automatic step(input string tag, input bit chk);
        logic [5:0] act;
        logic set, anyact, wr, rd;
        act = ~(pin_lvl ^ pin_pol);
        set = 1'b0;
        for (int k = 0; k < 3; k++)
            if (pair_en[k] && act[2*k] && act[2*k+1]) set = 1'b1;
        anyact = |act;
        wr = acc_en && acc_wr;
        rd = acc_en && !acc_wr;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_flag = 0; m_ie = 0; m_hze = 0; m_lock = 0; m_arm = 0;
        end else begin
            logic nf;
            nf = m_flag;
            if (wr && m_arm && !acc_wdata[15] && !anyact) nf = 1'b0;
            if (set) nf = 1'b1;
            if (wr) m_ie = acc_wdata[8];
            if (wr && !m_lock) begin m_hze = acc_wdata[9]; m_lock = 1'b1; end
            if (wr) m_arm = 1'b0;
            else if (rd && m_flag) m_arm = 1'b1;
            m_flag = nf;
        end
        acc_en = 1'b0; acc_wr = 1'b0;
        if (chk) begin
            q_rd.push_back({m_flag, 5'b0, m_hze, m_ie, 8'b0});
            q_irq.push_back(m_flag & m_ie);
            q_hiz.push_back(m_flag & m_hze);
            q_tag.push_back(tag);
        end
    endtask

    task automatic do_write(input logic [15:0] d, input string tag);
        acc_en = 1'b1; acc_wr = 1'b1; acc_wdata = d;
        step(tag, 1'b1);
    endtask

    task automatic do_read(input string tag);
        acc_en = 1'b1; acc_wr = 1'b0;
        step(tag, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Driver: stimulus sequence, one requirement per block.
    initial begin
        pin_pol = 6'b100110;
        pin_lvl = ~pin_pol;
        #1;
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) step("R1 reset", 1'b1);
        rst_n = 1'b1;
        // R3: all pins active but every pair disabled
        pair_en = 3'b000; pin_lvl = pins(6'h3F);
        step("R3 disabled pairs", 1'b1);
        step("R3 disabled pairs hold", 1'b1);
        // R3: one pin of a pair active only
        pair_en = 3'b111; pin_lvl = pins(6'b000001);
        step("R3 single pin", 1'b1);
        // R2: pair 1 overlap sets the flag, enables still 0 (R5, R6)
        pin_lvl = pins(6'b001100);
        step("R2 overlap sets flag", 1'b1);
        pin_lvl = pins(6'b000000);
        step("R2 flag sticky", 1'b1);
        // R4, R8, R7: write all ones, flag unaffected, enables loaded
        do_write(16'hFFFF, "R4 R8 write ones");
        // R8, R7, R5: unarmed write 0 keeps flag, bit 9 locked, ie drops
        do_write(16'h0000, "R8 unarmed clear R7 lock");
        // R9: armed clear with one pin active
        do_read("R8 read flag one");
        pin_lvl = pins(6'b010000);
        do_write(16'h0000, "R9 clear while pin active");
        // R10: arming consumed by previous write
        pin_lvl = pins(6'b000000);
        do_write(16'h0000, "R10 second write needs read");
        // R8: proper sequence clears, R5 ie set
        do_read("R8 read before clear");
        do_write(16'h0100, "R8 valid clear");
        // R8: read of 0 does not arm
        do_read("R8 read zero");
        pin_lvl = pins(6'b110000);
        step("R2 pair 2 overlap", 1'b1);
        pin_lvl = pins(6'b000000);
        do_write(16'h0000, "R8 read of zero does not arm");
        // R1 again, then R7 lock at 0 and R6 no hiz
        rst_n = 1'b0;
        step("R1 second reset", 1'b1);
        rst_n = 1'b1;
        pair_en = 3'b010;
        do_write(16'h0000, "R7 first write zero");
        do_write(16'h0200, "R7 later write ignored");
        pin_lvl = pins(6'b000011);
        step("R3 pair 0 disabled", 1'b1);
        pin_lvl = pins(6'b001100);
        step("R6 flag without hiz", 1'b1);
        pin_lvl = pins(6'b000000);
        step("R2 idle", 1'b1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule